// File: doc/BRIEF.md
# Compare and Test Flag Generator

This unit produces the condition flags that follow a compare or a test operation in a processor datapath. It takes a source operand, a destination operand, an operand size and an operation code, together with the five flags currently held. It returns the next value of those five flags one clock later. It never produces a writeback value: the subtraction exists only to derive flags, and both operands are left as they were.

Three operation kinds are supported. A plain compare evaluates destination minus source at byte, word or long width. An address compare subtracts a word source, sign-extended to full width, or a full-width source from a full-width destination. A test derives sign and zero from the destination alone. A fourth code passes the incoming flags through unchanged. The extend flag X is always carried across unchanged.

The byte width is a quarter of `DATA_W` and the word width is half of it. With the default `DATA_W` of 32, byte, word and long are 8, 16 and 32 bits.

Top module: `cmpflag_unit`

## Requirements
- R1: The output flag vector `flags_out` is {X,N,Z,V,C} on bits [4:0]. It is registered and reflects the inputs sampled at the previous rising clock edge. For a compare (`op_sel`=0), N equals the top bit of (destination − source) at the selected width. `size_sel` 0 selects byte (DATA_W/4 bits), 1 selects word (DATA_W/2 bits), and 2 selects long (DATA_W bits).
- R2: For a compare, Z is 1 exactly when the low bits of the difference at the selected width are all zero. Operand bits above the selected width have no effect on any flag.
- R3: For a compare, V is 1 when the operand signs differ and the sign of the difference differs from the sign of the destination.
- R4: For a compare, C is 1 when the unsigned source, taken at the selected width, is greater than the unsigned destination at that width.
- R5: For `op_sel` 0, 1 and 2, the X output equals the X input (`flags_in[4]`).
- R6: For a test (`op_sel`=2), N and Z come from the destination at the selected width, V and C are 0, and the source has no effect.
- R7: For an address compare (`op_sel`=1), flags are evaluated at DATA_W bits regardless of width. With `size_sel` 2 or 3 the full source is used; with `size_sel` 0 or 1 the low DATA_W/2 source bits are sign-extended.
- R8: With `op_sel`=3, all five output flags equal `flags_in`.
- R9: `size_sel`=3 behaves as long for every operation.
- R10: A synchronous active-high `rst` clears `flags_out` to 0 on the next rising edge.
- R11: At long width, comparing 1 against a destination of 0 gives N=1, Z=0, V=0, C=1. Comparing 1 against 1 gives N=0, Z=1, V=0, C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_op | input | DATA_W | Source operand |
| dst_op | input | DATA_W | Destination operand (address value for address compare) |
| size_sel | input | 2 | Width: 0 byte, 1 word, 2 or 3 long |
| op_sel | input | 2 | 0 compare, 1 address compare, 2 test, 3 hold |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| flags_out | output | 5 | Next flags {X,N,Z,V,C}, registered |

## Verification
The assertions assume that `op_sel`, `size_sel` and `flags_in` carry known values in every cycle once reset has been released. They also assume that a check of X, hold or borrow in the cycle after a given input only needs that one input cycle to be stable. The bench drives all inputs shortly after each rising edge, so each vector is held for a full cycle, and it sets defined values before the first edge. At a reduced `DATA_W` of 8, the sweeps visit every operand pair for long compares and for full-width address compares. Random upper bits are placed above the selected width so that masking is exercised without leaving the legal encodings.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_CMPA = 2'd1,
    OP_TST  = 2'd2,
    OP_HOLD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/cmpflag_align.sv
// Places both operands so that the selected width occupies the top bits.
// A single full-width subtractor then yields flags for every size.
module cmpflag_align
  import cmpflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_op,
  input  logic [DATA_W-1:0] dst_op,
  input  size_e             size,
  input  op_e               op,
  output logic [DATA_W-1:0] a_src,
  output logic [DATA_W-1:0] a_dst
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  function automatic logic [DATA_W-1:0] left_align(input logic [DATA_W-1:0] x,
                                                   input size_e sz);
    case (sz)
      SZ_BYTE: return {x[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
      SZ_WORD: return {x[HALF_W-1:0], {(DATA_W-HALF_W){1'b0}}};
      default: return x;
    endcase
  endfunction

  always_comb begin
    case (op)
      OP_CMPA: begin
        a_dst = dst_op;
        if (size == SZ_LONG || size == SZ_LALT)
          a_src = src_op;
        else
          a_src = {{(DATA_W-HALF_W){src_op[HALF_W-1]}}, src_op[HALF_W-1:0]};
      end
      OP_TST: begin
        a_dst = left_align(dst_op, size);
        a_src = '0;
      end
      default: begin
        a_dst = left_align(dst_op, size);
        a_src = left_align(src_op, size);
      end
    endcase
  end
endmodule

// File: rtl/cmpflag_eval.sv
// Full-width subtract of aligned operands and derivation of N, Z, V, C.
module cmpflag_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_src,
  input  logic [DATA_W-1:0] a_dst,
  output logic              n,
  output logic              z,
  output logic              v,
  output logic              c
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] res;

  always_comb begin
    diff = {1'b0, a_dst} - {1'b0, a_src};
    res  = diff[DATA_W-1:0];
    c    = diff[DATA_W];
    n    = res[MSB];
    z    = ~|res;
    v    = (a_dst[MSB] ^ a_src[MSB]) & (res[MSB] ^ a_dst[MSB]);
  end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_op,
  input  logic [DATA_W-1:0] dst_op,
  input  logic [1:0]        size_sel,
  input  logic [1:0]        op_sel,
  input  logic [4:0]        flags_in,
  output logic [4:0]        flags_out
);
  logic [DATA_W-1:0] a_src, a_dst;
  logic              n_w, z_w, v_w, c_w;
  ccr_t              cur, nxt, q;

  assign cur = ccr_t'(flags_in);

  cmpflag_align #(.DATA_W(DATA_W)) align_i (
    .src_op (src_op),
    .dst_op (dst_op),
    .size   (size_e'(size_sel)),
    .op     (op_e'(op_sel)),
    .a_src  (a_src),
    .a_dst  (a_dst)
  );

  cmpflag_eval #(.DATA_W(DATA_W)) eval_i (
    .a_src (a_src),
    .a_dst (a_dst),
    .n     (n_w),
    .z     (z_w),
    .v     (v_w),
    .c     (c_w)
  );

  always_comb begin
    if (op_e'(op_sel) == OP_HOLD) nxt = cur;
    else nxt = '{x: cur.x, n: n_w, z: z_w, v: v_w, c: c_w};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign flags_out = q;

  // R10: synchronous reset clears the flags
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> flags_out == 5'b0);

  // R5: X carried across every active operation
  assert_x_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (op_sel != 2'd3) |=> flags_out[4] == $past(flags_in[4]));

  // R6: test forces V and C low
  assert_test_vc_low_R6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'd2) |=> flags_out[1:0] == 2'b00);

  // R8: hold code passes all flags
  assert_hold_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'd3) |=> flags_out == $past(flags_in));

  // R2: identical operands compare as zero with no borrow or overflow
  assert_equal_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'd0 && src_op == dst_op) |=> flags_out[3:0] == 4'b0100);

  // R4/R7: full-width address compare borrows when source is larger
  assert_addr_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'd1 && size_sel[1] && src_op > dst_op) |=> flags_out[0]);
endmodule

// File: tb/cmpflag_unit_tb_top.sv
module cmpflag_unit_tb_top;
  localparam int W  = 8;
  localparam int HW = W / 2;
  localparam int BW = W / 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] src_op = '0;
  logic [W-1:0] dst_op = '0;
  logic [1:0]   size_sel = 2'd0;
  logic [1:0]   op_sel = 2'd3;
  logic [4:0]   flags_in = 5'd0;
  logic [4:0]   flags_out;
  int           errors = 0;
  int           checks = 0;

  always #5 clk = ~clk;

  cmpflag_unit #(.DATA_W(W)) dut_i (
    .clk (clk), .rst (rst), .src_op (src_op), .dst_op (dst_op),
    .size_sel (size_sel), .op_sel (op_sel), .flags_in (flags_in),
    .flags_out (flags_out)
  );

  function automatic logic [4:0] model(input logic [1:0] op, input logic [1:0] sz,
                                       input logic [W-1:0] s_in, input logic [W-1:0] d_in,
                                       input logic [4:0] fin);
    longint w, full, half, d, s, r, ds, ss, df, h;
    logic n, z, v, c;
    if (op == 2'd3) return fin;
    if (op == 2'd1) begin
      w = W;
      d = longint'(d_in);
      if (sz >= 2'd2) s = longint'(s_in);
      else begin
        h = longint'(s_in) % (longint'(1) << HW);
        s = (h >= (longint'(1) << (HW-1))) ? h + (longint'(1) << W) - (longint'(1) << HW) : h;
      end
    end else begin
      w = (sz == 2'd0) ? BW : (sz == 2'd1) ? HW : W;
      d = longint'(d_in) % (longint'(1) << w);
      s = (op == 2'd2) ? 0 : longint'(s_in) % (longint'(1) << w);
    end
    full = longint'(1) << w;
    half = full / 2;
    r = d - s;
    if (r < 0) r = r + full;
    n = (r >= half);
    z = (r == 0);
    c = (s > d);
    ds = (d >= half) ? d - full : d;
    ss = (s >= half) ? s - full : s;
    df = ds - ss;
    v = (df >= half) || (df < -half);
    return {fin[4], n, z, v, c};
  endfunction

  task automatic run_vec(input logic [1:0] op, input logic [1:0] sz,
                         input logic [W-1:0] s, input logic [W-1:0] d,
                         input logic [4:0] fin, input string tag);
    logic [4:0] exp_v;
    op_sel = op; size_sel = sz; src_op = s; dst_op = d; flags_in = fin;
    exp_v = model(op, sz, s, d, fin);
    @(posedge clk);
    #1;
    checks++;
    if (flags_out !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d size=%0d src=%h dst=%h actual=%b expected=%b",
               tag, op, sz, s, d, flags_out, exp_v);
    end
  endtask

  task automatic check_val(input logic [4:0] exp_v, input string tag);
    checks++;
    if (flags_out !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, flags_out, exp_v);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] s, d;
    // R10: reset state while inputs request pass-through of ones
    flags_in = 5'h1f; op_sel = 2'd3;
    repeat (3) @(posedge clk);
    #1;
    check_val(5'b0, "R10 reset");
    rst = 1'b0;

    // R11: corner cases at long width, X preserved
    run_vec(2'd0, 2'd2, 8'd1, 8'd0, 5'b10000, "R11 0-1");
    check_val(5'b11001, "R11 0-1 literal");
    run_vec(2'd0, 2'd2, 8'd1, 8'd1, 5'b01011, "R11 1-1");
    check_val(5'b00100, "R11 1-1 literal");

    // R1 R2 R3 R4 R5: compare at byte and word with random upper bits
    for (int sz = 0; sz < 2; sz++) begin
      for (int a = 0; a < (1 << HW); a++) begin
        for (int b = 0; b < (1 << HW); b++) begin
          if (sz == 0 && (a >= (1 << BW) || b >= (1 << BW))) continue;
          s = W'($urandom); d = W'($urandom);
          if (sz == 0) begin s[BW-1:0] = BW'(a); d[BW-1:0] = BW'(b); end
          else begin s[HW-1:0] = HW'(a); d[HW-1:0] = HW'(b); end
          run_vec(2'd0, 2'(sz), s, d, 5'($urandom), "R1/R2/R3/R4/R5 cmp narrow");
        end
      end
    end

    // R1 R3 R4: exhaustive long compare
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_vec(2'd0, 2'd2, W'(a), W'(b), 5'($urandom), "R1/R3/R4 cmp long");

    // R9: size code 3 acts as long
    for (int i = 0; i < 256; i++) begin
      run_vec(2'd0, 2'd3, W'($urandom), W'($urandom), 5'($urandom), "R9 cmp size3");
      run_vec(2'd2, 2'd3, W'($urandom), W'($urandom), 5'($urandom), "R9 tst size3");
    end

    // R7: address compare, word source sign-extended (size 1 and 0)
    for (int a = 0; a < (1 << HW); a++)
      for (int b = 0; b < (1 << W); b++) begin
        s = W'($urandom); s[HW-1:0] = HW'(a);
        run_vec(2'd1, 2'($urandom % 2), s, W'(b), 5'($urandom), "R7 cmpa word");
      end

    // R7: address compare, full source, long and alternate long code
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_vec(2'd1, ((a + b) % 2 == 0) ? 2'd2 : 2'd3, W'(a), W'(b),
                5'($urandom), "R7 cmpa long");

    // R6: test at every size, source random and ignored
    for (int sz = 0; sz < 3; sz++)
      for (int b = 0; b < (1 << W); b++)
        run_vec(2'd2, 2'(sz), W'($urandom), W'(b), 5'($urandom), "R6 tst");

    // R8: hold passes every flag pattern
    for (int f = 0; f < 32; f++)
      run_vec(2'd3, 2'($urandom), W'($urandom), W'($urandom), 5'(f), "R8 hold");

    // R10: reset mid-run clears flags
    op_sel = 2'd3; flags_in = 5'h1f; rst = 1'b1;
    @(posedge clk);
    #1;
    check_val(5'b0, "R10 reset mid-run");
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule